// File: doc/BRIEF.md
# Multi-Source Reset Qualification Controller

This block merges three kinds of reset request into one chip-wide active-high reset. The three kinds are a supply-detector level, an active-low reset pin, and three low-voltage comparator flags for the 0.9 V, 1.2 V and 1.5 V rails. A free-running reference clock samples every request. Each request passes through a two-flop synchronizer and then through a filter with its own assert and release times, counted in clock cycles. Excursions shorter than those times have no effect.

The supply path works in two steps. It first qualifies a supply-good state, then keeps its request active for a short stretch after supply-good rises. Any episode that involved the supply path ends with a long mode-configuration hold. The hold runs after the last active source has released, and a configuration-ready output rises only when it has elapsed. No filter runs until the reference clock has had a warm-up interval. The block also reports the qualified state of each source and keeps a sticky record of the causes. Software can clear that record bit by bit.

Every time is a parameter in cycles. Each default is derived from a clock-frequency parameter (24 MHz by default).

Top module: `rstq_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the outputs take these values: `chip_rst`=1, `cfg_ready`=0, `src_active`=5'b11111 and `cause`=5'b00001. Source bit positions are: [0] supply, [1] pin, [2] 0.9 V flag, [3] 1.2 V flag, [4] 1.5 V flag.
- R2: For the first WARM_CYC edges after `rst_n` rises, every filter stays idle. `src_active` stays all ones and `chip_rst` stays 1.
- R3: Each input passes two synchronizer flops. `ext_rst_n` held low for EXT_ASSERT_CYC sampled cycles sets `src_active[1]` on the edge EXT_ASSERT_CYC+2 after the change, and `chip_rst` rises one edge later. A shorter low has no effect.
- R4: `ext_rst_n` held high for EXT_RELEASE_CYC cycles clears `src_active[1]`, and a shorter high has no effect. When the supply path was not involved, `chip_rst` falls one edge after the last source clears, with no hold.
- R5: `por_det` (1 = supply above trip) must stay low for POR_OFF_CYC cycles before the supply path becomes active, and shorter dips are ignored. It must stay high for POR_ON_CYC cycles before supply-good is declared.
- R6: After supply-good is declared, `src_active[0]` stays 1 for STRETCH_CYC more edges.
- R7: `lvd_low[k]` (1 = rail low; [0] 0.9 V, [1] 1.2 V, [2] 1.5 V) activates `src_active[2+k]` after LVD_LO_CYC cycles for the first two rails and after LVD_HI_CYC cycles for the 1.5 V rail. It releases after LVD_REL_CYC cycles, and shorter pulses are ignored.
- R8: When the supply path has been active, `cfg_ready` falls on the edge after it activates. `cfg_ready` rises HOLD_CYC edges after the last active source clears, and `chip_rst` falls on the following edge.
- R9: `chip_rst` is 1 whenever any source is active, and it stays 1 until the last one releases. The hold starts from that last release.
- R10: `cause` sets the bit of a source when that source becomes active. The bits are sticky.
- R11: A 1 on a bit of `cause_clr` during a clock edge clears that bit of `cause` and leaves the others unchanged.
- R12: Activation of the supply path sets `cause` to 5'b00001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Synchronous active-low reset of the controller logic |
| por_det | input | 1 | Supply detector level, 1 = above trip (asynchronous) |
| ext_rst_n | input | 1 | External reset pin, active low (asynchronous) |
| lvd_low | input | 3 | Low-voltage flags for the 0.9/1.2/1.5 V rails, 1 = low (asynchronous) |
| cause_clr | input | 5 | Write-one-to-clear strobe for `cause` bits |
| chip_rst | output | 1 | Chip-wide reset, active high |
| cfg_ready | output | 1 | Mode-configuration hold has elapsed |
| src_active | output | 5 | Qualified state of each source |
| cause | output | 5 | Sticky reset-cause bits |

## Verification
The checker watches four behaviours on every cycle. Any active source forces reset on the next cycle. The filters do not move before warm-up ends. `cfg_ready` drops after supply activity, and reset releases only when `cfg_ready` is high. Cause bits disappear only through a clear strobe or supply activity. Only the bench scenarios can show the exact qualification counts of each source and the rejection of pulses one cycle too short. The same holds for the stretch length, for the hold length and the point it is counted from when sources overlap, and for the bit-level results of clearing.

// File: rtl/rstq_pkg.sv
// Package: shared constants and the time-to-cycle conversion used by the
// reset qualification controller. Assumes frequencies in kHz and times in ns.
package rstq_pkg;

    localparam int NSRC     = 5;   // supply, pin, three rail flags
    localparam int NLVD     = 3;
    localparam int SRC_POR  = 0;
    localparam int SRC_EXT  = 1;
    localparam int SRC_LVD0 = 2;

    // Round a duration in ns up to whole cycles of a clock given in kHz.
    function automatic int ns_to_cyc(input int khz, input longint ns);
        longint prod;
        prod = longint'(khz) * ns;
        return int'((prod + 64'd999999) / 64'd1000000);
    endfunction

endpackage

// File: rtl/rstq_sync.sv
// Module: two-flop synchronizer for a vector of asynchronous levels.
// Assumes each bit is an independent slow level; no bus coherence implied.
module rstq_sync #(
    parameter int         W       = 1,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta;

    // Capture then re-capture to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end

endmodule

// File: rtl/rstq_filter.sv
// Module: time-qualification filter. The output follows the request only
// after the request has differed from it for SET_CYC (to go active) or
// CLR_CYC (to go inactive) consecutive enabled cycles. Assumes both >= 1.
module rstq_filter #(
    parameter int   SET_CYC = 1,
    parameter int   CLR_CYC = 1,
    parameter logic INIT    = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic req,
    output logic active
);

    localparam int             MAXC    = (SET_CYC > CLR_CYC) ? SET_CYC : CLR_CYC;
    localparam int             CW      = $clog2(MAXC + 1);
    localparam logic [CW-1:0]  SET_LIM = CW'(SET_CYC - 1);
    localparam logic [CW-1:0]  CLR_LIM = CW'(CLR_CYC - 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    // Pick the qualification length for the pending direction.
    assign lim = active ? CLR_LIM : SET_LIM;

    // Count consecutive disagreeing cycles and flip on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= INIT;
            cnt    <= '0;
        end else if (!en || (req == active)) begin
            cnt <= '0;
        end else if (cnt == lim) begin
            active <= req;
            cnt    <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/rstq_ctrl.sv
// Module: reset qualification controller top. Synchronizes and filters the
// supply, pin and rail requests, stretches the supply request, applies the
// mode-configuration hold after supply episodes and keeps sticky causes.
// Assumes clk runs from power-up; rst_n is the controller's own bring-up reset.
module rstq_ctrl #(
    parameter int CLK_KHZ         = 24000,
    parameter int WARM_CYC        = rstq_pkg::ns_to_cyc(CLK_KHZ, 64'd5000),
    parameter int EXT_ASSERT_CYC  = rstq_pkg::ns_to_cyc(CLK_KHZ, 64'd1000),
    parameter int EXT_RELEASE_CYC = rstq_pkg::ns_to_cyc(CLK_KHZ, 64'd1000),
    parameter int POR_ON_CYC      = rstq_pkg::ns_to_cyc(CLK_KHZ, 64'd2000),
    parameter int POR_OFF_CYC     = rstq_pkg::ns_to_cyc(CLK_KHZ, 64'd11000),
    parameter int STRETCH_CYC     = rstq_pkg::ns_to_cyc(CLK_KHZ, 64'd200),
    parameter int LVD_LO_CYC      = rstq_pkg::ns_to_cyc(CLK_KHZ, 64'd8000),
    parameter int LVD_HI_CYC      = rstq_pkg::ns_to_cyc(CLK_KHZ, 64'd16000),
    parameter int LVD_REL_CYC     = rstq_pkg::ns_to_cyc(CLK_KHZ, 64'd1000),
    parameter int HOLD_CYC        = rstq_pkg::ns_to_cyc(CLK_KHZ, 64'd15000000)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      por_det,
    input  logic                      ext_rst_n,
    input  logic [rstq_pkg::NLVD-1:0] lvd_low,
    input  logic [rstq_pkg::NSRC-1:0] cause_clr,
    output logic                      chip_rst,
    output logic                      cfg_ready,
    output logic [rstq_pkg::NSRC-1:0] src_active,
    output logic [rstq_pkg::NSRC-1:0] cause
);

    import rstq_pkg::*;

    localparam int WCW = $clog2(WARM_CYC + 1);
    localparam int SCW = $clog2(STRETCH_CYC + 1);
    localparam int HCW = $clog2(HOLD_CYC + 1);

    logic [NSRC-1:0] raw_req;
    logic [NSRC-1:0] req_s;
    logic [NSRC-1:0] act_q;
    logic [NSRC-1:0] rise;
    logic [NLVD-1:0] lvd_act;
    logic [WCW-1:0]  warm_cnt;
    logic            warm_done;
    logic            supply_bad;
    logic            ext_act;
    logic [SCW-1:0]  str_cnt;
    logic            por_active;
    logic            por_inv;
    logic [HCW-1:0]  hold_cnt;

    // Present every source as an active-high request.
    assign raw_req = {lvd_low, ~ext_rst_n, ~por_det};

    rstq_sync #(.W(NSRC), .RST_VAL('1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_req),
        .q     (req_s)
    );

    // Hold all filters idle until the reference clock has warmed up.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warm_cnt  <= '0;
            warm_done <= 1'b0;
        end else if (!warm_done) begin
            if (warm_cnt == WCW'(WARM_CYC - 1)) warm_done <= 1'b1;
            else                                warm_cnt  <= warm_cnt + 1'b1;
        end
    end

    rstq_filter #(.SET_CYC(POR_OFF_CYC), .CLR_CYC(POR_ON_CYC), .INIT(1'b1)) u_por_f (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (warm_done),
        .req    (req_s[SRC_POR]),
        .active (supply_bad)
    );

    rstq_filter #(.SET_CYC(EXT_ASSERT_CYC), .CLR_CYC(EXT_RELEASE_CYC), .INIT(1'b1)) u_ext_f (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (warm_done),
        .req    (req_s[SRC_EXT]),
        .active (ext_act)
    );

    for (genvar g = 0; g < NLVD; g++) begin : g_lvd
        localparam int SET = (g == NLVD - 1) ? LVD_HI_CYC : LVD_LO_CYC;
        rstq_filter #(.SET_CYC(SET), .CLR_CYC(LVD_REL_CYC), .INIT(1'b1)) u_lvd_f (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (warm_done),
            .req    (req_s[SRC_LVD0 + g]),
            .active (lvd_act[g])
        );
    end

    // Keep the supply request alive for a fixed stretch after supply-good.
    always_ff @(posedge clk) begin
        if (!rst_n)              str_cnt <= SCW'(STRETCH_CYC);
        else if (supply_bad)     str_cnt <= SCW'(STRETCH_CYC);
        else if (str_cnt != '0)  str_cnt <= str_cnt - 1'b1;
    end

    assign por_active = supply_bad | (str_cnt != '0);
    assign src_active = {lvd_act, ext_act, por_active};

    // Remember previous source states to detect new activations.
    always_ff @(posedge clk) begin
        if (!rst_n) act_q <= '1;
        else        act_q <= src_active;
    end

    assign rise = src_active & ~act_q;

    // Sticky causes: supply activation restarts the record, clears are per bit.
    always_ff @(posedge clk) begin
        if (!rst_n)             cause <= NSRC'(1) << SRC_POR;
        else if (rise[SRC_POR]) cause <= rise;
        else                    cause <= (cause & ~cause_clr) | rise;
    end

    // Mode-configuration hold counted from the last release of a supply episode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            por_inv   <= 1'b1;
            cfg_ready <= 1'b0;
            hold_cnt  <= '0;
        end else if (por_active) begin
            por_inv   <= 1'b1;
            cfg_ready <= 1'b0;
            hold_cnt  <= '0;
        end else if (|src_active) begin
            hold_cnt  <= '0;
        end else if (por_inv) begin
            if (hold_cnt == HCW'(HOLD_CYC - 1)) begin
                por_inv   <= 1'b0;
                cfg_ready <= 1'b1;
                hold_cnt  <= '0;
            end else begin
                hold_cnt  <= hold_cnt + 1'b1;
            end
        end
    end

    // Registered chip reset: any source, warm-up or pending hold keeps it high.
    always_ff @(posedge clk) begin
        if (!rst_n) chip_rst <= 1'b1;
        else        chip_rst <= ~warm_done | (|src_active) | por_inv;
    end

endmodule

// File: rtl/rstq_ctrl_chk.sv
// Module: cycle-by-cycle properties of the reset qualification controller,
// attached to every instance of the top through the bind below.
module rstq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       warm_done,
    input logic       chip_rst,
    input logic       cfg_ready,
    input logic [4:0] src_active,
    input logic [4:0] cause,
    input logic [4:0] cause_clr
);

    // R2: nothing qualifies before warm-up ends.
    p_warm_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !warm_done |-> (src_active == 5'b11111));

    // R9: any active source keeps chip reset high on the next cycle.
    p_src_holds_rst_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_active) |=> chip_rst);

    // R8: supply activity withdraws configuration readiness.
    p_cfg_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        src_active[0] |=> !cfg_ready);

    // R8: reset releases only once the hold has elapsed.
    p_release_after_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(chip_rst) |-> cfg_ready);

    // R10: cause bits vanish only through a clear strobe or supply activity.
    p_cause_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(cause) & ~cause)) |-> ($past(src_active[0]) || (|$past(cause_clr))));

endmodule

bind rstq_ctrl rstq_ctrl_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .warm_done  (warm_done),
    .chip_rst   (chip_rst),
    .cfg_ready  (cfg_ready),
    .src_active (src_active),
    .cause      (cause),
    .cause_clr  (cause_clr)
);

// File: tb/test_rstq_ctrl.sv
module test_rstq_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int WARM_C  = 20;
    localparam int EXT_A   = 6;
    localparam int EXT_R   = 8;
    localparam int POR_ON  = 5;
    localparam int POR_OFF = 12;
    localparam int STR_C   = 4;
    localparam int LVD_LO  = 7;
    localparam int LVD_HI  = 14;
    localparam int LVD_REL = 3;
    localparam int HOLD_C  = 50;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       por_det;
    logic       ext_rst_n;
    logic [2:0] lvd_low;
    logic [4:0] cause_clr;
    logic       chip_rst;
    logic       cfg_ready;
    logic [4:0] src_active;
    logic [4:0] cause;

    int nchk  = 0;
    int nfail = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rstq_ctrl #(
        .WARM_CYC(WARM_C), .EXT_ASSERT_CYC(EXT_A), .EXT_RELEASE_CYC(EXT_R),
        .POR_ON_CYC(POR_ON), .POR_OFF_CYC(POR_OFF), .STRETCH_CYC(STR_C),
        .LVD_LO_CYC(LVD_LO), .LVD_HI_CYC(LVD_HI), .LVD_REL_CYC(LVD_REL),
        .HOLD_CYC(HOLD_C)
    ) i_rstq_ctrl (
        .clk(clk), .rst_n(rst_n), .por_det(por_det), .ext_rst_n(ext_rst_n),
        .lvd_low(lvd_low), .cause_clr(cause_clr), .chip_rst(chip_rst),
        .cfg_ready(cfg_ready), .src_active(src_active), .cause(cause)
    );

    // Edge after reset release on which the last source clears at start-up.
    function automatic int startup_last();
        int a, b, c, m;
        a = WARM_C + POR_ON + STR_C;
        b = WARM_C + EXT_R;
        c = WARM_C + LVD_REL;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // A pulse shorter than its qualification length must leave no trace.
    function automatic bit pulse_takes(int len, int thr);
        return (len >= thr);
    endfunction

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: run did not finish");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; por_det = 1'b1; ext_rst_n = 1'b1; lvd_low = 3'b000; cause_clr = 5'b0;
        step(3);
        chk("R1 chip_rst", chip_rst, 1);
        chk("R1 cfg_ready", cfg_ready, 0);
        chk("R1 src_active", src_active, 5'b11111);
        chk("R1 cause", cause, 5'b00001);

        // Warm-up and start-up release
        rst_n = 1'b1;
        step(WARM_C);
        chk("R2 idle at warm end", src_active, 5'b11111);
        chk("R2 chip_rst", chip_rst, 1);
        step(LVD_REL - 1);
        chk("R2 still idle", src_active, 5'b11111);
        step(1);
        chk("R7 rails release first", src_active, 5'b00011);
        step(startup_last() + HOLD_C - 1 - (WARM_C + LVD_REL));
        chk("R8 cfg before hold end", cfg_ready, 0);
        step(1);
        chk("R8 cfg at hold end", cfg_ready, 1);
        chk("R8 chip_rst still high", chip_rst, 1);
        step(1);
        chk("R8 chip_rst released", chip_rst, 0);

        // Pin qualification
        ext_rst_n = 1'b0; step(EXT_A - 1); ext_rst_n = 1'b1; step(EXT_A + 4);
        chk("R3 short low ignored", {chip_rst, src_active}, 6'b0);
        ext_rst_n = 1'b0; step(EXT_A + 1);
        chk("R3 not yet", src_active[1], 0);
        step(1);
        chk("R3 pin active", src_active[1], 1);
        chk("R3 chip_rst lags", chip_rst, 0);
        step(1);
        chk("R3 chip_rst high", chip_rst, 1);
        step(2);
        chk("R10 cause pin", cause, 5'b00011);
        chk("R4 cfg untouched", cfg_ready, 1);
        ext_rst_n = 1'b1; step(EXT_R - 1); ext_rst_n = 1'b0; step(EXT_R + 4);
        chk("R4 short high ignored", {chip_rst, src_active[1]}, 2'b11);
        ext_rst_n = 1'b1; step(EXT_R + 2);
        chk("R4 pin released", src_active, 5'b0);
        chk("R4 chip_rst still high", chip_rst, 1);
        step(1);
        chk("R4 no hold", chip_rst, 0);

        // Rail flags
        lvd_low[0] = 1'b1; step(LVD_LO - 1); lvd_low[0] = 1'b0; step(LVD_LO + 4);
        chk("R7 short 0.9V ignored", {chip_rst, src_active}, 6'b0);
        lvd_low[0] = 1'b1; step(LVD_LO + 1);
        chk("R7 0.9V not yet", src_active[2], 0);
        step(1);
        chk("R7 0.9V active", src_active[2], 1);
        step(1);
        chk("R9 chip_rst from rail", chip_rst, 1);
        lvd_low[0] = 1'b0; step(LVD_REL + 2);
        chk("R7 0.9V released", src_active, 5'b0);
        step(1);
        chk("R7 chip_rst released", chip_rst, 0);
        lvd_low[2] = 1'b1; step(LVD_HI - 1); lvd_low[2] = 1'b0; step(LVD_HI + 4);
        chk("R7 short 1.5V ignored", {chip_rst, src_active}, 6'b0);
        lvd_low[2] = 1'b1; step(LVD_HI + 1);
        chk("R7 1.5V not yet", src_active[4], 0);
        step(1);
        chk("R7 1.5V active", src_active[4], 1);
        lvd_low[2] = 1'b0; step(LVD_REL + 3);
        chk("R7 1.5V released", {chip_rst, src_active}, 6'b0);
        chk("R10 cause accumulates", cause, 5'b10111);

        // Write-one-to-clear
        cause_clr = 5'b00010; step(1); cause_clr = 5'b0;
        chk("R11 clear pin bit", cause, 5'b10101);

        // Supply path
        por_det = 1'b0; step(POR_OFF - 1); por_det = 1'b1; step(POR_OFF + 4);
        chk("R5 short dip ignored", {chip_rst, cfg_ready, src_active}, 7'b0100000);
        chk("R5 cause untouched", cause, 5'b10101);
        por_det = 1'b0; step(POR_OFF + 1);
        chk("R5 not yet", src_active[0], 0);
        step(1);
        chk("R5 supply active", src_active[0], 1);
        step(1);
        chk("R8 cfg dropped", {chip_rst, cfg_ready}, 2'b10);
        step(2);
        chk("R12 cause restarted", cause, 5'b00001);
        por_det = 1'b1; step(POR_ON + STR_C + 1);
        chk("R6 stretch holds", src_active[0], 1);
        step(1);
        chk("R6 stretch ends", src_active[0], 0);
        step(HOLD_C - 1);
        chk("R8 hold running", {chip_rst, cfg_ready}, 2'b10);
        step(1);
        chk("R8 hold done", {chip_rst, cfg_ready}, 2'b11);
        step(1);
        chk("R8 released", chip_rst, 0);

        // Overlap: pin outlasts the supply episode
        ext_rst_n = 1'b0; step(EXT_A + 3);
        chk("R9 pin reset", chip_rst, 1);
        por_det = 1'b0; step(POR_OFF + 3);
        chk("R9 both active", src_active, 5'b00011);
        por_det = 1'b1; step(POR_ON + STR_C + 3);
        chk("R9 pin keeps reset", {chip_rst, src_active}, 6'b100010);
        ext_rst_n = 1'b1; step(EXT_R + 2);
        chk("R9 last released", src_active, 5'b0);
        step(HOLD_C - 1);
        chk("R9 hold from last", {chip_rst, cfg_ready}, 2'b10);
        step(1);
        chk("R9 hold done", cfg_ready, 1);
        step(1);
        chk("R9 released", chip_rst, 0);

        // Random short glitches on every input
        void'($urandom(32'd4711));
        for (int i = 0; i < 40; i++) begin
            int sel, len, thr;
            sel = int'($urandom % 5);
            case (sel)
                0: thr = POR_OFF;
                1: thr = EXT_A;
                4: thr = LVD_HI;
                default: thr = LVD_LO;
            endcase
            len = 1 + int'($urandom % 32'(thr - 1));
            case (sel)
                0: por_det = 1'b0;
                1: ext_rst_n = 1'b0;
                default: lvd_low[sel - 2] = 1'b1;
            endcase
            step(len);
            por_det = 1'b1; ext_rst_n = 1'b1; lvd_low = 3'b000;
            step(4);
            chk("R3 R5 R7 random glitch", {chip_rst, src_active},
                pulse_takes(len, thr) ? 6'b111111 : 6'b0);
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule